// File: doc/BRIEF.md
# Cellular Multi-Operand Accumulator

This block adds N operands of N bits each inside a small array of bit cells and returns their sum modulo 2^N. Unsigned and two's complement operands give the same bit result. The array holds N operand rows and one carry row. The first row holds the running sum. The second row holds the operand currently being added. The rows below it form a queue that climbs one row per step. A full-adder step is not done in one combinational pass. It is split into four clocked transitions: a first half-adder transition, a second half-adder transition, an OR transition that merges the two carries, and a shift transition that advances the queue and moves the carry row one column toward the MSB.

A job enters through a valid/ready slave port that carries all N operands at once. The port accepts only while the array is idle and no earlier result is waiting, so s_ready is low from acceptance until the result has been taken. The result leaves through a valid/ready master port. m_data and m_valid hold steady under back-pressure until m_ready is seen high at a clock edge. A separate done pin pulses for one cycle when the last transition completes.

Top module: `ca_accumulator`

## Requirements
- R1: After reset, s_ready is 1, m_valid is 0 and done is 0.
- R2: m_data equals the sum of the N operands modulo 2^N. Operand i sits in s_data bits [i*N +: N].
- R3: m_valid and done rise exactly 8N-4 clock edges after the edge that accepted the job (s_valid and s_ready both high). This covers 2N-1 full-adder steps of four transitions each.
- R4: done is high for exactly one cycle per job, and m_valid is high in that cycle.
- R5: Operands read as two's complement give a result equal to their signed sum wrapped to N bits.
- R6: While m_valid is high and m_ready is low, m_valid stays high, m_data does not change and s_ready is 0. An s_valid offered during that time starts no job.
- R7: While a job is computing, s_ready is 0 and s_valid is ignored. The result belongs only to the accepted operands.
- R8: Carries that ripple through the whole width, or run past bit N-1, are handled correctly. Bits past N-1 are dropped, so an all-ones set gives -N mod 2^N and 0xFF+1 gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Operand set offered |
| s_ready | output | 1 | Array idle and no result pending |
| s_data | input | N*N | N operands, operand i at bits [i*N +: N] |
| m_valid | output | 1 | Result available |
| m_ready | input | 1 | Consumer takes the result |
| m_data | output | N | Sum modulo 2^N |
| done | output | 1 | One-cycle pulse at completion |

## Verification
The bench goes after the carry paths that a faulty cell rule would break. An all-ones operand set and a 0xFF+1 pair push a carry through every column and off the top; a wrong carry shift or a carry row that misses the OR merge gives a wrong low or high bit there. Latency is measured edge by edge, so a sequencer that runs one step short leaves carries unabsorbed, and one that runs long shows up in the count. It also holds the output under back-pressure while offering a fresh job, and it offers new operands while a job is busy. A handshake that leaks would start a second job or overwrite the queue, and the scoreboard would then see an extra or corrupted sum.

// File: rtl/ca_acc_pkg.sv
package ca_acc_pkg;
  typedef enum logic [1:0] {
    PH_HA1   = 2'd0,
    PH_HA2   = 2'd1,
    PH_OR    = 2'd2,
    PH_SHIFT = 2'd3
  } phase_e;
endpackage

// File: rtl/ca_acc_seq.sv
module ca_acc_seq #(
  parameter int N = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  output logic                busy,
  output ca_acc_pkg::phase_e  phase,
  output logic                done
);
  localparam int LAST = 8 * N - 4;
  localparam int CW   = $clog2(LAST + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      phase <= ca_acc_pkg::PH_HA1;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy  <= 1'b1;
        cnt   <= '0;
        phase <= ca_acc_pkg::PH_HA1;
      end else if (busy) begin
        phase <= ca_acc_pkg::phase_e'(phase + 2'd1);
        cnt   <= cnt + 1'b1;
        if (cnt == CW'(LAST - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ca_acc_row.sv
module ca_acc_row #(
  parameter int N   = 8,
  parameter int ROW = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  ca_acc_pkg::phase_e phase,
  input  logic [N-1:0]       load_val,
  input  logic [N-1:0]       north,
  input  logic [N-1:0]       south,
  input  logic [N-1:0]       carry,
  output logic [N-1:0]       cells,
  output logic               mark_top,
  output logic               mark_sec
);
  localparam bit IS_TOP = (ROW == 0);
  localparam bit IS_SEC = (ROW == 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cells    <= '0;
      mark_top <= IS_TOP;
      mark_sec <= IS_SEC;
    end else if (load) begin
      cells    <= load_val;
      mark_top <= IS_TOP;
      mark_sec <= IS_SEC;
    end else if (step) begin
      unique case (phase)
        ca_acc_pkg::PH_HA1: begin
          if (mark_top)      cells <= cells ^ south;
          else if (mark_sec) cells <= cells & north;
        end
        ca_acc_pkg::PH_HA2: begin
          if (mark_top) cells <= cells ^ carry;
        end
        ca_acc_pkg::PH_OR: begin
          cells <= cells;
        end
        ca_acc_pkg::PH_SHIFT: begin
          if (!mark_top) cells <= south;
        end
        default: cells <= cells;
      endcase
    end
  end
endmodule

// File: rtl/ca_acc_carry.sv
module ca_acc_carry #(
  parameter int N = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  ca_acc_pkg::phase_e phase,
  input  logic [N-1:0]       top,
  input  logic [N-1:0]       sec,
  output logic [N-1:0]       carry
);
  always_ff @(posedge clk) begin
    if (!rst_n || load) begin
      carry <= '0;
    end else if (step) begin
      unique case (phase)
        ca_acc_pkg::PH_HA1:   carry <= carry;
        ca_acc_pkg::PH_HA2:   carry <= top & carry;
        ca_acc_pkg::PH_OR:    carry <= sec | carry;
        ca_acc_pkg::PH_SHIFT: carry <= {carry[N-2:0], 1'b0};
        default:              carry <= carry;
      endcase
    end
  end
endmodule

// File: rtl/ca_accumulator.sv
module ca_accumulator #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           s_valid,
  output logic           s_ready,
  input  logic [N*N-1:0] s_data,
  output logic           m_valid,
  input  logic           m_ready,
  output logic [N-1:0]   m_data,
  output logic           done
);
  ca_acc_pkg::phase_e phase;
  logic               busy;
  logic               accept;
  logic               m_pend;
  logic [N-1:0]       rows [N];
  logic [N-1:0]       mk_top;
  logic [N-1:0]       mk_sec;
  logic [N-1:0]       top_vec;
  logic [N-1:0]       sec_vec;
  logic [N-1:0]       carry;

  assign s_ready = !busy && !m_valid;
  assign accept  = s_valid && s_ready;

  ca_acc_seq #(.N(N)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .busy  (busy),
    .phase (phase),
    .done  (done)
  );

  for (genvar r = 0; r < N; r++) begin : g_row
    logic [N-1:0] north_v;
    logic [N-1:0] south_v;
    if (r == 0) begin : g_first
      assign north_v = '0;
    end else begin : g_mid
      assign north_v = rows[r-1];
    end
    if (r == N - 1) begin : g_last
      assign south_v = '0;
    end else begin : g_inner
      assign south_v = rows[r+1];
    end
    ca_acc_row #(.N(N), .ROW(r)) u_row (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .step     (busy),
      .phase    (phase),
      .load_val (s_data[r*N +: N]),
      .north    (north_v),
      .south    (south_v),
      .carry    (carry),
      .cells    (rows[r]),
      .mark_top (mk_top[r]),
      .mark_sec (mk_sec[r])
    );
  end

  always_comb begin
    top_vec = '0;
    sec_vec = '0;
    for (int r = 0; r < N; r++) begin
      top_vec = top_vec | (rows[r] & {N{mk_top[r]}});
      sec_vec = sec_vec | (rows[r] & {N{mk_sec[r]}});
    end
  end

  ca_acc_carry #(.N(N)) u_carry (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .step  (busy),
    .phase (phase),
    .top   (top_vec),
    .sec   (sec_vec),
    .carry (carry)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_pend <= 1'b0;
    end else if (done) begin
      m_pend <= !m_ready;
    end else if (m_pend && m_ready) begin
      m_pend <= 1'b0;
    end
  end

  assign m_valid = done || m_pend;
  assign m_data  = top_vec;
endmodule

// File: rtl/ca_accumulator_chk.sv
module ca_accumulator_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         s_valid,
  input logic         s_ready,
  input logic         m_valid,
  input logic         m_ready,
  input logic [N-1:0] m_data,
  input logic         done,
  input logic         busy
);
  localparam int LAST = 8 * N - 4;
  localparam int LW   = $clog2(LAST + 1) + 1;

  logic [LW-1:0] lat;
  logic          tracking;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat      <= '0;
      tracking <= 1'b0;
    end else if (s_valid && s_ready) begin
      lat      <= '0;
      tracking <= 1'b1;
    end else if (tracking) begin
      lat <= lat + 1'b1;
      if (done) tracking <= 1'b0;
    end
  end

  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tracking && lat == LW'(LAST)));
  p_done_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> m_valid);
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
  p_block_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> !s_ready);
  p_block_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !s_ready);
endmodule

bind ca_accumulator ca_accumulator_chk #(.N(N)) u_chk (.*);

// File: tb/tb_ca_accumulator.sv
`timescale 1ns/1ps
module tb_ca_accumulator;
  localparam int N    = 8;
  localparam int LAST = 8 * N - 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           s_valid = 1'b0;
  logic           s_ready;
  logic [N*N-1:0] s_data = '0;
  logic           m_valid;
  logic           m_ready = 1'b1;
  logic [N-1:0]   m_data;
  logic           done;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic [N-1:0] exp_q [$];
  string        tag_q [$];

  always #2.5 clk = ~clk;

  ca_accumulator #(.N(N)) dut (.*);

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] ref_sum(input logic [N*N-1:0] d);
    logic [N-1:0] s = '0;
    for (int i = 0; i < N; i++) s = s + d[i*N +: N];
    return s;
  endfunction

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all R): actual %0d cycles expected under 20000", cyc);
      finish_up();
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && m_valid && m_ready) begin
        if (exp_q.size() == 0) begin
          chk("R7 unexpected result", m_data, -1);
        end else begin
          automatic logic [N-1:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          chk(t, m_data, e);
        end
      end
    end
  end

  // drive one job; junk > 0 offers other operands during the busy window
  task automatic run_case(input logic [N*N-1:0] d, input int junk, input string tag);
    int k;
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    s_data  = d;
    s_valid = 1'b1;
    exp_q.push_back(ref_sum(d));
    tag_q.push_back(tag);
    @(negedge clk);
    s_valid = 1'b0;
    if (junk > 0) begin
      s_valid = 1'b1;
      s_data  = ~d;
      chk("R7 s_ready low while busy", s_ready, 0);
    end
    k = 0;
    while (!m_valid && k < LAST + 10) begin
      @(negedge clk);
      k++;
      if (k >= junk) s_valid = 1'b0;
    end
    chk("R3 latency", k, LAST);
    chk("R4 done with result", done, 1);
    @(negedge clk);
    chk("R4 done pulse ends", done, 0);
  endtask

  initial begin
    logic [N*N-1:0] d;
    logic [N-1:0]   held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 s_ready", s_ready, 1);
    chk("R1 m_valid", m_valid, 0);
    chk("R1 done", done, 0);

    run_case('0, 0, "R2 zeros");
    for (int i = 0; i < N; i++) d[i*N +: N] = N'(i + 1);
    run_case(d, 0, "R2 one to N");
    for (int i = 0; i < N; i++) d[i*N +: N] = N'(1) << i;
    run_case(d, 0, "R2 walking bit");
    run_case({N*N{1'b1}}, 0, "R8 all ones");
    d = '0;
    d[0 +: N] = 8'hFF;
    d[N +: N] = 8'h01;
    run_case(d, 0, "R8 full ripple wrap");
    d[0*N +: N] = -8'sd3;  d[1*N +: N] = 8'sd5;
    d[2*N +: N] = -8'sd128; d[3*N +: N] = 8'sd127;
    d[4*N +: N] = -8'sd1;  d[5*N +: N] = 8'sd2;
    d[6*N +: N] = 8'sd0;   d[7*N +: N] = 8'sd10;
    run_case(d, 0, "R5 signed mix");
    for (int i = 0; i < N; i++) d[i*N +: N] = N'(i * 37 + 5);
    run_case(d, 20, "R7 busy offer ignored");

    // back-pressure
    m_ready = 1'b0;
    for (int i = 0; i < N; i++) d[i*N +: N] = N'(200 - i * 9);
    run_case(d, 0, "R6 held result");
    held = ref_sum(d);
    s_data  = ~d;
    s_valid = 1'b1;
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      chk("R6 m_valid held", m_valid, 1);
      chk("R6 m_data stable", m_data, held);
      chk("R6 s_ready low", s_ready, 0);
    end
    s_valid = 1'b0;
    m_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R6 released", m_valid, 0);
    chk("R6 no job from blocked offer", s_ready, 1);

    run_case('0, 0, "R2 zeros after back-pressure");
    repeat (3) @(negedge clk);
    chk("R2 scoreboard drained", exp_q.size(), 0);
    finish_up();
  end
endmodule